// File: doc/BRIEF.md
# Comma-Based Word Aligner

This block turns a recovered serial bit stream into 10-bit characters. A qualifying enable accepts one bit per clock. Characters leave the block in two alternating word phases, A and B, and each phase has a one-cycle strobe of its own. One phase-A character followed by one phase-B character forms a 20-bit word pair. The strobes take the place of the two complementary recovered clocks that a real receiver would produce.

While the search enable is high, the block watches every bit position for the 7-bit comma `0011111`, with the leftmost bit received first. Suppose a comma shows up anywhere other than bits 0..6 of a phase-B character. That covers a shifted bit offset, a comma that straddles two characters, or a comma in bits 0..6 of a phase-A character. In each of these cases the block moves its character boundary and its phase so that the comma lands at bit 0 of a phase-B character. The move only ever lengthens the time between strobes. If a strobe would come too soon or out of turn, it is dropped. Up to three characters before the first comma, and that comma itself, may be lost. Every later character comes out whole.

A flag marks each phase-B character that begins with the comma. While the search enable is low, the current boundary is kept whatever the data, and the flag stays low.

Top module: `comma_word_aligner`

## Requirements
- R1: A bit is taken only on a clock with `bit_en` high. Bit 0 of `char_out` is the earliest of the ten bits of a character. In steady state, a character is completed every 10 accepted bits.
- R2: `strobe_a` and `strobe_b` are never high together and are single-cycle pulses. After reset the first strobe is `strobe_a`, and from then on the strobes alternate. A strobe, together with its new `char_out`, appears one clock after the edge that accepted the character's last bit.
- R3: The comma is `char_out` bits 0..6 = 0,0,1,1,1,1,1 (bit 0 first). `comma_flag` rises together with a `strobe_b` whose character starts with the comma and while `align_en` is high. It is never high for a phase-A character, and it stays unchanged until the next strobe.
- R4: With `align_en` high, a comma at any other bit offset or phase moves the boundary. The next comma sent an even number of characters later is then output as a phase-B character with `comma_flag` high. All characters after it are output unchanged, in alternating phase.
- R5: At least 10 accepted bits separate any two strobes, and the first strobe after reset.
- R6: With `align_en` low, no realignment happens. Strobes stay exactly 10 accepted bits apart, and `comma_flag` stays low.
- R7: Synchronous active-high `rst` clears `char_out`, both strobes and `comma_flag`. The block restarts in phase A at bit offset 0.
- R8: A comma that already sits at bit 0 of a phase-B character causes no loss. The characters before it and after it are all output.
- R9: Clocks with `bit_en` low change neither the boundary nor the bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Recovered serial bit |
| align_en | input | 1 | Enables comma search, realignment and the flag |
| char_out | output | CHAR_W | Last completed character, bit 0 earliest |
| strobe_a | output | 1 | One-cycle pulse: a phase-A character is on `char_out` |
| strobe_b | output | 1 | One-cycle pulse: a phase-B character is on `char_out` |
| comma_flag | output | 1 | The phase-B character shown starts with an aligned comma |

## Verification
A character, its strobe and its comma flag all come out one clock after the edge that accepts the tenth bit. The checks are therefore keyed to strobe pulses, not to fixed delays after a stimulus. The monitor samples on the falling edge. It counts accepted bits between strobes, which gives the spacing checks for R5 and R6. On each strobe it pops the expected character, phase and flag from the scoreboard queue. Because the characters lost during realignment are not predictable, the monitor waits until the first character it expects appears and only then compares. A queue that is not empty after the flush characters counts as a failure.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
   typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_t;

   // width of the bit-time counter since the last strobe; it must hold
   // the longest stretched interval (under three characters) plus headroom
   function automatic int since_width(input int char_w);
      return $clog2(3 * char_w + 1) + 1;
   endfunction
endpackage

// File: rtl/cwa_shift_hist.sv
module cwa_shift_hist #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] hist_nx
);
   logic [W-1:0] hist_q;

   // newest bit enters at the top, so bit 0 is always the oldest
   assign hist_nx = {din, hist_q[W-1:1]};

   always_ff @(posedge clk) begin
      if (rst)           hist_q <= '0;
      else if (shift_en) hist_q <= hist_nx;
   end
endmodule

// File: rtl/cwa_pattern_match.sv
module cwa_pattern_match #(
   parameter int           W   = 7,
   parameter logic [W-1:0] PAT = '0
) (
   input  logic [W-1:0] win,
   output logic         hit
);
   logic [W-1:0] eq;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign eq[i] = (win[i] == PAT[i]);
   end

   assign hit = &eq;
endmodule

// File: rtl/cwa_phase_ctrl.sv
module cwa_phase_ctrl
   import cwa_pkg::*;
#(
   parameter int CHAR_W  = 10,
   parameter int COMMA_W = 7,
   parameter int SINCE_W = 6
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   bit_en,
   input  logic   align_en,
   input  logic   tail_hit,
   output logic   emit,
   output phase_t emit_phase
);
   localparam int CNT_W = $clog2(CHAR_W);
   localparam logic [CNT_W-1:0]   LAST_BIT   = CNT_W'(CHAR_W - 1);
   localparam logic [CNT_W-1:0]   TAIL_POS   = CNT_W'(COMMA_W - 1);
   localparam logic [CNT_W-1:0]   RESTART    = CNT_W'(COMMA_W);
   localparam logic [SINCE_W-1:0] MIN_GAP    = SINCE_W'(CHAR_W);
   localparam logic [SINCE_W-1:0] SINCE_MAX  = '1;

   logic [CNT_W-1:0]   cnt_q;
   logic [SINCE_W-1:0] since_q, since_inc;
   phase_t             cur_q, last_q;
   logic               aligned_here, realign, complete;

   assign since_inc    = (since_q == SINCE_MAX) ? since_q : since_q + 1'b1;
   assign aligned_here = (cur_q == PH_B) && (cnt_q == TAIL_POS);
   assign realign      = bit_en && align_en && tail_hit && !aligned_here;
   assign complete     = bit_en && !realign && (cnt_q == LAST_BIT);
   // a strobe goes out only in turn and never early; otherwise it is
   // dropped, which stretches the interval up to the next strobe
   assign emit         = complete && (cur_q != last_q) && (since_inc >= MIN_GAP);
   assign emit_phase   = cur_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         since_q <= '0;
         cur_q   <= PH_A;
         last_q  <= PH_B;
      end else if (bit_en) begin
         if (realign) begin
            // the comma began COMMA_W bits ago: restart a phase-B character there
            cnt_q   <= RESTART;
            cur_q   <= PH_B;
            since_q <= since_inc;
         end else if (complete) begin
            cnt_q   <= '0;
            cur_q   <= (cur_q == PH_A) ? PH_B : PH_A;
            since_q <= emit ? '0 : since_inc;
            if (emit) last_q <= cur_q;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
            since_q <= since_inc;
         end
      end
   end
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
   import cwa_pkg::*;
#(
   parameter int                 CHAR_W    = 10,
   parameter int                 COMMA_W   = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              bit_in,
   input  logic              align_en,
   output logic [CHAR_W-1:0] char_out,
   output logic              strobe_a,
   output logic              strobe_b,
   output logic              comma_flag
);
   localparam int SINCE_W = since_width(CHAR_W);

   if (COMMA_W < 2 || COMMA_W >= CHAR_W) begin : g_bad_comma
      $error("comma width must be at least 2 and below the character width");
   end
   if (CHAR_W < 4) begin : g_bad_char
      $error("character width too small");
   end

   logic [CHAR_W-1:0] hist_nx;
   logic              tail_hit, head_hit, emit, flag_q;
   phase_t            emit_phase;

   cwa_shift_hist #(.W(CHAR_W)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .shift_en (bit_en),
      .din      (bit_in),
      .hist_nx  (hist_nx)
   );

   // newest COMMA_W bits: a comma just finished arriving at any offset
   cwa_pattern_match #(.W(COMMA_W), .PAT(COMMA_PAT)) u_tail (
      .win (hist_nx[CHAR_W-1 -: COMMA_W]),
      .hit (tail_hit)
   );

   // oldest COMMA_W bits of the character being completed
   cwa_pattern_match #(.W(COMMA_W), .PAT(COMMA_PAT)) u_head (
      .win (hist_nx[COMMA_W-1:0]),
      .hit (head_hit)
   );

   cwa_phase_ctrl #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .SINCE_W(SINCE_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .bit_en     (bit_en),
      .align_en   (align_en),
      .tail_hit   (tail_hit),
      .emit       (emit),
      .emit_phase (emit_phase)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         char_out <= '0;
         strobe_a <= 1'b0;
         strobe_b <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         strobe_a <= emit && (emit_phase == PH_A);
         strobe_b <= emit && (emit_phase == PH_B);
         if (emit) begin
            char_out <= hist_nx;
            flag_q   <= align_en && (emit_phase == PH_B) && head_hit;
         end
      end
   end

   assign comma_flag = flag_q && align_en;
endmodule

// File: rtl/cwa_chk.sv
module cwa_chk #(
   parameter int CHAR_W = 10
) (
   input logic clk,
   input logic rst,
   input logic bit_en,
   input logic align_en,
   input logic strobe_a,
   input logic strobe_b,
   input logic comma_flag
);
   localparam int GW = $clog2(4 * CHAR_W) + 1;
   localparam logic [GW-1:0] GMAX = '1;

   logic [GW-1:0] gap_q;
   logic          last_b_q, low_span_q;
   logic          any_strobe;

   assign any_strobe = strobe_a || strobe_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q      <= '0;
         last_b_q   <= 1'b1;
         low_span_q <= 1'b1;
      end else if (any_strobe) begin
         gap_q      <= bit_en ? GW'(1) : '0;
         last_b_q   <= strobe_b;
         low_span_q <= !align_en;
      end else begin
         if (bit_en && gap_q != GMAX) gap_q <= gap_q + 1'b1;
         low_span_q <= low_span_q && !align_en;
      end
   end

   // R2: one strobe at a time, in alternating phase
   a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
      $onehot0({strobe_a, strobe_b}));
   a_r2_a_after_b: assert property (@(posedge clk) disable iff (rst)
      strobe_a |-> last_b_q);
   a_r2_b_after_a: assert property (@(posedge clk) disable iff (rst)
      strobe_b |-> !last_b_q);
   // R5: never shorter than one character of bit times
   a_r5_min_gap: assert property (@(posedge clk) disable iff (rst)
      any_strobe |-> gap_q >= GW'(CHAR_W));
   // R6: with the search off for a whole interval it is exactly nominal
   a_r6_hold_gap: assert property (@(posedge clk) disable iff (rst)
      (any_strobe && low_span_q) |-> gap_q == GW'(CHAR_W));
   // R3: flag only while a phase-B character is shown
   a_r3_flag_phase_b: assert property (@(posedge clk) disable iff (rst)
      comma_flag |-> (strobe_b || (last_b_q && !strobe_a)));
   // R7: quiet right after reset
   a_r7_reset_quiet: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!strobe_a && !strobe_b && !comma_flag));
endmodule

bind comma_word_aligner cwa_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bit_en     (bit_en),
   .align_en   (align_en),
   .strobe_a   (strobe_a),
   .strobe_b   (strobe_b),
   .comma_flag (comma_flag)
);

// File: tb/comma_word_aligner_tb.sv
module comma_word_aligner_tb;
   localparam logic [9:0] K_A    = 10'b0101111100; // comma, tail 0,1,0
   localparam logic [9:0] K_B    = 10'b0001111100; // comma, tail 0,0,0
   localparam logic [9:0] FILL   = 10'h2AA;        // 0,1,0,1,... earliest first
   localparam logic [6:0] PAT    = 7'b1111100;

   logic       clk = 0, rst = 1, bit_en = 0, bit_in = 0, align_en = 1;
   logic [9:0] char_out;
   logic       strobe_a, strobe_b, comma_flag;

   int checks = 0, errors = 0, cycles = 0;
   int mon_gap = 0, hold_strobes = 0;
   bit mon_last_b = 1, armed = 0, hold_mode = 0, done = 0;
   logic [11:0] exp_q[$];   // {flag, phase_b, char}

   always #5 clk = ~clk;

   comma_word_aligner u_dut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .align_en(align_en),
      .char_out(char_out), .strobe_a(strobe_a), .strobe_b(strobe_b), .comma_flag(comma_flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] safe_data();
      logic [9:0] v;
      bit bad;
      do begin
         v = 10'($urandom);
         bad = 0;
         for (int i = 0; i < 8; i++) if (v[i] && v[i+1] && v[i+2]) bad = 1;
      end while (bad);
      return v;
   endfunction

   // monitor: strobes appear one clock after the last bit; sample at negedge
   always @(negedge clk) begin
      if (rst) begin
         mon_gap = 0; mon_last_b = 1; armed = 0;
      end else begin
         if (strobe_a || strobe_b) begin
            chk(mon_gap >= 10, "R5 gap", mon_gap, 10);
            chk(!(strobe_a && strobe_b) && (strobe_b != mon_last_b), "R2 alternate",
                {strobe_a, strobe_b}, {mon_last_b, !mon_last_b});
            mon_last_b = strobe_b;
            if (hold_mode) begin
               hold_strobes++;
               chk(mon_gap == 10, "R6 gap", mon_gap, 10);
               chk(!comma_flag, "R6 flag", comma_flag, 0);
               chk(char_out[6:0] != PAT, "R6 no realign", char_out, 0);
            end
            if (!armed && exp_q.size() > 0 && char_out == exp_q[0][9:0]) armed = 1;
            if (armed) begin
               logic [11:0] e;
               e = exp_q.pop_front();
               chk(char_out == e[9:0], "R4 char", char_out, e[9:0]);
               chk(strobe_b == e[10], "R2 phase", strobe_b, e[10]);
               chk(comma_flag == e[11], "R3 flag", comma_flag, e[11]);
               if (exp_q.size() == 0) armed = 0;
            end
            mon_gap = 0;
         end
         if (bit_en) mon_gap++;
      end
   end

   task automatic send_bit(input logic b);
      bit_in = b; bit_en = 1;
      @(posedge clk); #2;
      bit_en = 0;
      repeat ($urandom_range(0, 1)) begin @(posedge clk); #2; end   // R9 gaps
   endtask

   task automatic send_char(input logic [9:0] c);
      for (int i = 0; i < 10; i++) send_bit(c[i]);
   endtask

   task automatic push(input logic [9:0] c, input bit ph_b);
      exp_q.push_back({ph_b && (c[6:0] == PAT), ph_b, c});
   endtask

   task automatic do_reset();
      rst = 1; bit_en = 0;
      repeat (3) @(posedge clk);
      #2 rst = 0;
   endtask

   task automatic finish_case(input string req);
      repeat (8) @(posedge clk);
      #2;
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
      exp_q.delete();
      armed = 0;
   endtask

   // pattern: lead data, comma, five data, comma, eight data, flush
   task automatic comma_burst(input int lead, input bit expect_first);
      logic [9:0] d[16];
      for (int i = 0; i < 16; i++) d[i] = safe_data();
      if (expect_first) begin
         push(K_A, 1);
         for (int i = 0; i < 5; i++) push(d[i], i % 2 == 1);
      end
      push(K_B, 1);
      for (int i = 0; i < 8; i++) push(d[5 + i], i % 2 == 1);
      for (int i = 0; i < lead; i++) send_char(d[13 + (i % 3)]);
      send_char(K_A);
      for (int i = 0; i < 5; i++) send_char(d[i]);
      send_char(K_B);
      for (int i = 0; i < 8; i++) send_char(d[5 + i]);
      send_char(FILL); send_char(FILL);
   endtask

   initial begin
      logic [9:0] x, y;
      // R7: reset state
      do_reset();
      @(negedge clk);
      chk(char_out == 0 && !strobe_a && !strobe_b && !comma_flag, "R7 reset",
          {char_out, strobe_a, strobe_b, comma_flag}, 0);
      // R1 R9: first two characters, bit 0 first, phase A then B
      x = safe_data(); y = safe_data();
      @(posedge clk); #2;
      push(x, 0); push(y, 1);
      send_char(x); send_char(y); send_char(FILL);
      finish_case("R1 R9 first characters");

      // R4 R8: comma at every offset of the pair
      for (int k = 0; k < 20; k++) begin
         do_reset();
         for (int i = 0; i < k; i++) send_bit(1'(i % 2));
         comma_burst(3, k == 0);
         finish_case(k == 0 ? "R8 aligned comma" : "R4 realign");
      end

      // R6: search off, shift the stream by three bits, boundary must hold
      align_en = 0;
      hold_mode = 1;
      send_bit(0); send_bit(1); send_bit(0);
      for (int i = 0; i < 2; i++) send_char(safe_data());
      send_char(K_A);
      for (int i = 0; i < 5; i++) send_char(safe_data());
      send_char(K_B);
      for (int i = 0; i < 3; i++) send_char(safe_data());
      send_char(FILL);
      repeat (4) @(posedge clk);
      #2 hold_mode = 0;
      chk(hold_strobes >= 12, "R6 strobes held", hold_strobes, 12);

      // R4: search back on, recovers to the shifted boundary
      align_en = 1;
      comma_burst(2, 0);
      finish_case("R4 recover after hold");

      done = 1;
   end

   initial begin
      while (!done && cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule